// File: doc/BRIEF.md
# Command-Driven SPI Master Sequencer

This block is an SPI master engine that executes one serial transfer for each command it is handed. A command selects which of four chip-select lines are driven and to what level. It also picks the word length, either the fixed 8 bits or a length taken from a global length code, and the idle gap that follows the transfer, either a short fixed gap or a programmable multiple of 32 clocks. The block shifts the transmit word out MSB first on SCK with the clock idling low, where the first bit is valid when the chip selects change and data is sampled on rising edges. It captures the incoming word right-aligned. It then holds the chip selects through the gap, so that the gap also serves as the deselect interval, before it reports completion.

A host pulses `start` with the command fields and transmit word valid. `busy` covers the whole shift-plus-gap window, and a one-cycle `done` marks the end. An active-low slave-select input is watched at all times. If it is seen low, the block takes a sticky mode fault, abandons any transfer at once and releases the chip selects. The fault stays until the host clears it.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset, `busy`, `done`, `sck`, `mode_fault` and `rx_data` are all zero and `cs_lvl` is all ones.
- R2: A `start` pulse sampled while idle and fault-free is accepted. From the next cycle `busy` is 1 and `cs_lvl` equals the latched `cmd_cs`, held unchanged until `busy` falls, and then `cs_lvl` returns to all ones. A `start` while busy has no effect on `cs_lvl` or on the transfer.
- R3: Word length N is 8 when `cmd_len_sel`=0. When `cmd_len_sel`=1, length code 4'b0000 gives 16, codes 4'b1000..4'b1111 give 8..15 (8 plus the low three bits), and codes 4'b0001..4'b0111 give 8.
- R4: SCK idles low. Each half period lasts H = `cfg_half_div` clocks, with 0 treated as 1. MOSI carries `tx_data[N-1:0]` MSB first and is stable at every rising SCK edge. SCK makes exactly N rising edges.
- R5: MISO is sampled on rising SCK edges, MSB first. At the end of the transfer `rx_data` holds the N received bits right-aligned, with the upper bits zero.
- R6: With `cmd_gap_en`=0 the post-transfer gap is 17 clocks.
- R7: With `cmd_gap_en`=1 the gap is 32×`cfg_gap_mult` clocks, and a `cfg_gap_mult` of 0 gives 8192 clocks.
- R8: `busy` is high for exactly 2·H·N + gap cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: `ss_n` sampled low at a clock edge sets `mode_fault` and, at that same edge, ends any transfer: `busy` low, `cs_lvl` all ones, `sck` low, and no `done` pulse, even in the last gap cycle.
- R10: `mode_fault` stays set until `fault_clr` is sampled high with `ss_n` high. If a set and a clear fall in the same cycle, the set wins. `start` is ignored while `mode_fault` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command launch pulse |
| cmd_cs | input | 4 | Chip-select levels for this command |
| cmd_gap_en | input | 1 | 1: programmed gap, 0: fixed 17-clock gap |
| cmd_len_sel | input | 1 | 1: length from `cfg_len_code`, 0: 8 bits |
| cfg_len_code | input | 4 | Global length code |
| cfg_gap_mult | input | 8 | Gap multiplier (units of 32 clocks, 0 = 8192) |
| cfg_half_div | input | 8 | SCK half period in clocks (0 = 1) |
| tx_data | input | 16 | Transmit word, right-aligned |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select, fault source |
| fault_clr | input | 1 | Clears `mode_fault` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_lvl | output | 4 | Chip-select outputs, idle all ones |
| busy | output | 1 | Transfer or gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received word, right-aligned |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
Two collisions are provoked deliberately. The first is a slave-select fault in the final gap cycle, the very edge at which the gap would expire and `done` would fire. The bench counts the expected busy window, drops `ss_n` on the last busy cycle, and requires `busy` low, no `done` and `mode_fault` set at the next sample. The second is a fault set against a fault clear: `fault_clr` is raised while `ss_n` is still low, and the flag must survive until the clear comes with `ss_n` high.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the command-driven SPI master.
// Assumes a 4-line chip-select bank whose idle level is all ones.
package spi_cmd_pkg;
    localparam int CS_LINES = 4;
    localparam int STD_GAP_CLKS = 17;
    localparam int GAP_UNIT_LOG2 = 5;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/spi_len_decode.sv
// Word-length decoder. Turns the per-command select bit and the global
// length code into a bit count. Assumes the full word is 2**BITS_W bits:
// code 0 wraps to the full width, codes with the MSB set add their low bits
// to the base of half the width, and the remaining codes fall back to the base.
module spi_len_decode #(
    parameter int BITS_W = 4,
    parameter int LEN_W  = 5
) (
    input  logic              len_sel,
    input  logic [BITS_W-1:0] code,
    output logic [LEN_W-1:0]  len
);
    localparam int BASE_LEN = 2 ** (BITS_W - 1);
    localparam int FULL_LEN = 2 ** BITS_W;

    // Map select bit and code to a length in bits.
    always_comb begin
        if (!len_sel) begin
            len = LEN_W'(BASE_LEN);
        end else if (code == '0) begin
            len = LEN_W'(FULL_LEN);
        end else if (code[BITS_W-1]) begin
            len = LEN_W'(BASE_LEN) + LEN_W'(code[BITS_W-2:0]);
        end else begin
            len = LEN_W'(BASE_LEN);
        end
    end
endmodule

// File: rtl/spi_gap_select.sv
// Post-transfer gap selector. Produces the gap length in clocks: a fixed
// short gap, or a multiple of 2**UNIT_LOG2 clocks, where a zero multiplier
// stands for the largest count (2**(MULT_W+UNIT_LOG2)).
module spi_gap_select #(
    parameter int MULT_W    = 8,
    parameter int UNIT_LOG2 = 5,
    parameter int STD_GAP   = 17,
    parameter int GAP_W     = MULT_W + UNIT_LOG2 + 1
) (
    input  logic              gap_en,
    input  logic [MULT_W-1:0] mult,
    output logic [GAP_W-1:0]  gap
);
    localparam int ZERO_SHIFT = MULT_W + UNIT_LOG2;

    // Pick the fixed gap or the scaled programmed gap.
    always_comb begin
        if (!gap_en) begin
            gap = GAP_W'(STD_GAP);
        end else if (mult == '0) begin
            gap = GAP_W'(1) << ZERO_SHIFT;
        end else begin
            gap = GAP_W'(mult) << UNIT_LOG2;
        end
    end
endmodule

// File: rtl/spi_bit_engine.sv
// Serial bit engine. Generates SCK (idle low, data valid before the first
// rising edge), shifts the transmit word out MSB first, and shifts MISO in on
// rising edges. Assumes load and abort are never asked for by the caller in
// a way that needs both honoured; abort wins. last_edge flags the cycle that
// ends with the final falling SCK edge.
module spi_bit_engine #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              abort,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word,
    output logic              last_edge
);
    logic              active_q;
    logic              sck_q;
    logic [DIV_W-1:0]  half_cnt_q;
    logic [DIV_W-1:0]  half_lim_q;
    logic [LEN_W-1:0]  bits_left_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [LEN_W-1:0]  align_amt;
    logic              half_end;

    // Left-justify the transmit word so its bit N-1 sits at the MSB.
    assign align_amt = LEN_W'(DATA_W) - len;
    // A half period ends when the counter reaches its limit.
    assign half_end  = active_q && (half_cnt_q == half_lim_q - DIV_W'(1));
    assign last_edge = half_end && sck_q && (bits_left_q == LEN_W'(1));
    assign sck       = sck_q;
    assign mosi      = tx_sh_q[DATA_W-1];
    assign rx_word   = rx_sh_q;

    // Half-period timing, SCK toggling and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            sck_q       <= 1'b0;
            half_cnt_q  <= '0;
            half_lim_q  <= DIV_W'(1);
            bits_left_q <= '0;
            tx_sh_q     <= '0;
            rx_sh_q     <= '0;
        end else if (abort) begin
            active_q   <= 1'b0;
            sck_q      <= 1'b0;
            half_cnt_q <= '0;
        end else if (load) begin
            active_q    <= 1'b1;
            sck_q       <= 1'b0;
            half_cnt_q  <= '0;
            half_lim_q  <= (half_div == '0) ? DIV_W'(1) : half_div;
            bits_left_q <= len;
            tx_sh_q     <= tx_word << align_amt;
            rx_sh_q     <= '0;
        end else if (active_q) begin
            if (half_end) begin
                half_cnt_q <= '0;
                sck_q      <= ~sck_q;
                if (!sck_q) begin
                    rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
                end else begin
                    tx_sh_q     <= tx_sh_q << 1;
                    bits_left_q <= bits_left_q - LEN_W'(1);
                    if (bits_left_q == LEN_W'(1)) begin
                        active_q <= 1'b0;
                    end
                end
            end else begin
                half_cnt_q <= half_cnt_q + DIV_W'(1);
            end
        end
    end

    // R3: every accepted length lies between half and full width.
    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |-> (len >= LEN_W'(DATA_W / 2) && len <= LEN_W'(DATA_W)));
    // R4: the clock is back low after the final falling edge.
    assert_sck_parks_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_edge |=> !sck_q);
    // R4: SCK holds its level inside a half period.
    assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !half_end && !abort && !load) |=> $stable(sck_q));
endmodule

// File: rtl/spi_gap_timer.sv
// Post-transfer gap timer. Loaded with a nonzero length, it runs for exactly
// that many cycles and flags the last one on expire. Abort stops it silently.
module spi_gap_timer #(
    parameter int GAP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             abort,
    input  logic [GAP_W-1:0] gap_len,
    output logic             expire
);
    logic             running_q;
    logic [GAP_W-1:0] remain_q;

    assign expire = running_q && (remain_q == GAP_W'(1));

    // Count down the remaining gap cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            remain_q  <= '0;
        end else if (abort) begin
            running_q <= 1'b0;
            remain_q  <= '0;
        end else if (load) begin
            running_q <= 1'b1;
            remain_q  <= gap_len;
        end else if (running_q) begin
            remain_q <= remain_q - GAP_W'(1);
            if (expire) begin
                running_q <= 1'b0;
            end
        end
    end

    // R7: a zero-length gap is never requested.
    assert_gap_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |-> (gap_len != '0));
    // R8: a running timer never holds a zero count.
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (remain_q != '0));
endmodule

// File: rtl/spi_cmd_master.sv
// Command-driven SPI master sequencer, top level. Accepts one command per
// start pulse, drives the chip selects, runs the bit engine, then holds the
// chip selects through the selected gap before a one-cycle done. A low
// slave-select input sets a sticky mode fault and aborts at once.
// Assumes DATA_W == 2**BITS_W.
module spi_cmd_master #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int MULT_W = 8,
    parameter int BITS_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [spi_cmd_pkg::CS_LINES-1:0]    cmd_cs,
    input  logic                                cmd_gap_en,
    input  logic                                cmd_len_sel,
    input  logic [BITS_W-1:0]                   cfg_len_code,
    input  logic [MULT_W-1:0]                   cfg_gap_mult,
    input  logic [DIV_W-1:0]                    cfg_half_div,
    input  logic [DATA_W-1:0]                   tx_data,
    input  logic                                miso,
    input  logic                                ss_n,
    input  logic                                fault_clr,
    output logic                                sck,
    output logic                                mosi,
    output logic [spi_cmd_pkg::CS_LINES-1:0]    cs_lvl,
    output logic                                busy,
    output logic                                done,
    output logic [DATA_W-1:0]                   rx_data,
    output logic                                mode_fault
);
    import spi_cmd_pkg::*;

    localparam int LEN_W = $clog2(DATA_W + 1);
    localparam int GAP_W = MULT_W + GAP_UNIT_LOG2 + 1;

    seq_state_t          state_q;
    logic [CS_LINES-1:0] cs_q;
    logic [GAP_W-1:0]    gap_q;
    logic                done_q;
    logic                fault_q;
    logic [DATA_W-1:0]   rx_q;
    logic [LEN_W-1:0]    len_dec;
    logic [GAP_W-1:0]    gap_dec;
    logic [DATA_W-1:0]   rx_word;
    logic                last_edge;
    logic                gap_expire;
    logic                fault_evt;
    logic                accept;

    assign fault_evt = !ss_n;
    assign accept    = start && (state_q == SEQ_IDLE) && !fault_q && ss_n;

    spi_len_decode #(.BITS_W(BITS_W), .LEN_W(LEN_W)) u_len (
        .len_sel (cmd_len_sel),
        .code    (cfg_len_code),
        .len     (len_dec)
    );

    spi_gap_select #(.MULT_W(MULT_W), .UNIT_LOG2(GAP_UNIT_LOG2),
                     .STD_GAP(STD_GAP_CLKS), .GAP_W(GAP_W)) u_gapsel (
        .gap_en (cmd_gap_en),
        .mult   (cfg_gap_mult),
        .gap    (gap_dec)
    );

    spi_bit_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .abort     (fault_evt),
        .half_div  (cfg_half_div),
        .len       (len_dec),
        .tx_word   (tx_data),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .rx_word   (rx_word),
        .last_edge (last_edge)
    );

    spi_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (last_edge && !fault_evt),
        .abort   (fault_evt),
        .gap_len (gap_q),
        .expire  (gap_expire)
    );

    // Sequence state and chip-select levels; a fault forces idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cs_q    <= '1;
            gap_q   <= GAP_W'(STD_GAP_CLKS);
        end else if (fault_evt) begin
            state_q <= SEQ_IDLE;
            cs_q    <= '1;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= SEQ_SHIFT;
                        cs_q    <= cmd_cs;
                        gap_q   <= gap_dec;
                    end
                end
                SEQ_SHIFT: begin
                    if (last_edge) state_q <= SEQ_GAP;
                end
                SEQ_GAP: begin
                    if (gap_expire) begin
                        state_q <= SEQ_IDLE;
                        cs_q    <= '1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // One-cycle completion pulse when the gap runs out without a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= !fault_evt && (state_q == SEQ_GAP) && gap_expire;
    end

    // Capture the received word at the final edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rx_q <= '0;
        else if (last_edge && !fault_evt) rx_q <= rx_word;
    end

    // Sticky fault flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_q <= 1'b0;
        else if (fault_evt) fault_q <= 1'b1;
        else if (fault_clr) fault_q <= 1'b0;
    end

    assign cs_lvl     = cs_q;
    assign busy       = (state_q != SEQ_IDLE);
    assign done       = done_q;
    assign rx_data    = rx_q;
    assign mode_fault = fault_q;

    // R2: chip selects are idle whenever the block is not busy.
    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_lvl == '1));
    // R2: chip selects hold steady across a busy window.
    assert_cs_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_lvl));
    // R8: done is a single-cycle pulse.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done marks the first idle cycle after a busy window.
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R9: a low slave select aborts with no completion.
    assert_fault_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n |=> (mode_fault && !busy && !done && !sck));
    // R10: the fault flag holds until cleared.
    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !fault_clr) |=> mode_fault);
    // R10: no transfer starts while the fault flag is set.
    assert_no_start_in_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode_fault) |=> !busy);
endmodule

// File: tb/test_spi_cmd_master.sv
`timescale 1ns/1ps
module test_spi_cmd_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd_cs = 4'hF;
    logic        cmd_gap_en = 1'b0;
    logic        cmd_len_sel = 1'b0;
    logic [3:0]  cfg_len_code = 4'h0;
    logic [7:0]  cfg_gap_mult = 8'h0;
    logic [7:0]  cfg_half_div = 8'h1;
    logic [15:0] tx_data = 16'h0;
    logic        ss_n = 1'b1;
    logic        fault_clr = 1'b0;
    logic        miso;
    logic        sck, mosi, busy, done, mode_fault;
    logic [3:0]  cs_lvl;
    logic [15:0] rx_data;

    logic [15:0] slave_sh = 16'h0;
    logic [15:0] mosi_cap = 16'h0;
    int vectors = 0;
    int miscompares = 0;

    assign miso = slave_sh[15];

    always #5 clk = ~clk;

    spi_cmd_master i_spi_cmd_master (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_cs(cmd_cs),
        .cmd_gap_en(cmd_gap_en), .cmd_len_sel(cmd_len_sel),
        .cfg_len_code(cfg_len_code), .cfg_gap_mult(cfg_gap_mult),
        .cfg_half_div(cfg_half_div), .tx_data(tx_data), .miso(miso),
        .ss_n(ss_n), .fault_clr(fault_clr), .sck(sck), .mosi(mosi),
        .cs_lvl(cs_lvl), .busy(busy), .done(done), .rx_data(rx_data),
        .mode_fault(mode_fault)
    );

    // Bench slave: changes data on falling SCK, captures MOSI on rising SCK.
    always @(negedge sck) slave_sh = slave_sh << 1;
    always @(posedge sck) mosi_cap = {mosi_cap[14:0], mosi};

    function automatic int exp_len(input logic sel, input logic [3:0] code);
        if (!sel) return 8;
        if (code == 4'h0) return 16;
        if (code[3]) return 8 + int'(code[2:0]);
        return 8;
    endfunction

    function automatic int exp_gap(input logic en, input logic [7:0] mult);
        if (!en) return 17;
        if (mult == 8'h0) return 8192;
        return 32 * int'(mult);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [3:0] cs, input logic gen, input logic lsel,
                           input logic [3:0] code, input logic [7:0] mult,
                           input logic [7:0] div, input logic [15:0] tx,
                           input logic [15:0] slave, input bit poke);
        int n = exp_len(lsel, code);
        int g = exp_gap(gen, mult);
        int h = (div == 8'h0) ? 1 : int'(div);
        int mask = (1 << n) - 1;
        int cnt = 0;
        @(negedge clk);
        cmd_cs = cs; cmd_gap_en = gen; cmd_len_sel = lsel;
        cfg_len_code = code; cfg_gap_mult = mult; cfg_half_div = div;
        tx_data = tx;
        slave_sh = slave << (16 - n);
        mosi_cap = 16'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        chk("R2 cs levels", int'(cs_lvl), int'(cs));
        while (busy && cnt < 20000) begin
            cnt++;
            if (poke && cnt == 3) begin
                cmd_cs = ~cs; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (poke && cnt == 3) chk("R2 start while busy ignored", int'(cs_lvl), int'(cs));
        end
        start = 1'b0;
        chk(gen ? "R7 busy window" : "R6 busy window", cnt, 2 * h * n + g);
        chk("R3 bit count", (cnt - g) / (2 * h), n);
        chk("R8 done pulse", int'(done), 1);
        chk("R2 cs released", int'(cs_lvl), 15);
        chk("R5 rx word", int'(rx_data), int'(slave) & mask);
        chk("R4 mosi word", int'(mosi_cap) & mask, int'(tx) & mask);
        @(negedge clk);
        chk("R8 done single", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 cs", int'(cs_lvl), 15);
        chk("R1 sck", int'(sck), 0);
        chk("R1 fault", int'(mode_fault), 0);
        chk("R1 rx", int'(rx_data), 0);

        // Directed corners: default length, wrap code, reserved code, gaps.
        run_cmd(4'hE, 1'b0, 1'b0, 4'h0, 8'h00, 8'd1, 16'hA5C3, 16'h5A3C, 1'b0);
        run_cmd(4'h5, 1'b1, 1'b1, 4'h0, 8'h01, 8'd2, 16'hBEEF, 16'hC0DE, 1'b1);
        run_cmd(4'h0, 1'b0, 1'b1, 4'h3, 8'h00, 8'd1, 16'h00FF, 16'h0081, 1'b0);
        run_cmd(4'h9, 1'b0, 1'b1, 4'hF, 8'h00, 8'd3, 16'h7123, 16'h4ACE, 1'b0);
        run_cmd(4'hC, 1'b1, 1'b1, 4'h8, 8'h00, 8'd0, 16'h1234, 16'h00FF, 1'b0);
        run_cmd(4'h3, 1'b1, 1'b0, 4'h0, 8'hFF, 8'd1, 16'h0096, 16'h0069, 1'b0);

        // Random commands with bounded gaps.
        for (int i = 0; i < 40; i++) begin
            run_cmd(4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                    8'($urandom % 16), 8'($urandom % 4), 16'($urandom),
                    16'($urandom), 1'b0);
        end

        // R9: fault in the middle of a transfer.
        @(negedge clk);
        cmd_cs = 4'h6; cmd_gap_en = 1'b0; cmd_len_sel = 1'b0; cfg_half_div = 8'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        chk("R9 busy dropped", int'(busy), 0);
        chk("R9 cs idle", int'(cs_lvl), 15);
        chk("R9 sck low", int'(sck), 0);
        chk("R9 fault set", int'(mode_fault), 1);
        chk("R9 no done", int'(done), 0);
        // R10: set and clear together; set wins.
        fault_clr = 1'b1;
        @(negedge clk);
        chk("R10 set beats clear", int'(mode_fault), 1);
        fault_clr = 1'b0; ss_n = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 start ignored in fault", int'(busy), 0);
        chk("R10 cs idle in fault", int'(cs_lvl), 15);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R10 fault cleared", int'(mode_fault), 0);

        // R9: fault in the last gap cycle suppresses done.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < 33; k++) @(negedge clk);
        chk("R8 still busy in last gap cycle", int'(busy), 1);
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        chk("R9 last-cycle abort busy", int'(busy), 0);
        chk("R9 last-cycle no done", int'(done), 0);
        chk("R9 last-cycle fault", int'(mode_fault), 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R10 cleared again", int'(mode_fault), 0);

        // Block recovers after a fault.
        run_cmd(4'hA, 1'b1, 1'b1, 4'hC, 8'h02, 8'd1, 16'h0F0F, 16'h0ABC, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule